// File: doc/BRIEF.md
# Adaptive Cache Shrink/Expand Controller

This controller decides when a shared second-level cache, organised as a set of ways, may be shrunk toward zero ways so that the chip can drop into a lower-voltage idle state. It also decides when the cache must grow back. It watches the current clock frequency against a programmable limit, the idle state of each of two cores, a package-idle indication and a pending-interrupt flag. A countdown measures how long the package has stayed active.

Each time both cores newly sit in the deepest idle state under low-frequency, non-streaming conditions, the controller grants a flush budget of one eighth, one quarter or one half of the cache. It spends that budget as a series of chunk requests to an external flush engine. Chunks start at the highest enabled way and run upward through its lines. A way is power-gated as soon as its last line is flushed. Between chunks the controller re-checks the freeze conditions. When every way is gated it raises a ready flag so the supply may be lowered further. On wake-up from that state it re-enables at least two ways and requests a clear of all valid bits.

Top module: `cache_resize_ctrl`

## Requirements
- R1: After reset all 8 ways are enabled, no way is gated, and no flush request, valid-clear request or deep-ready flag is active.
- R2: A shrink session starts only on the cycle both cores become C4 (state code 4), with `freq_cur < freq_thresh` and the active countdown not expired. A frequency equal to the threshold starts nothing.
- R3: On a qualifying entry the line budget is loaded from `frac_sel`: 0 gives 1/8, 1 gives 1/4, 2 or 3 give 1/2 of all lines.
- R4: Each chunk covers min(clamped chunk size, lines left in the way, budget left) lines. `chunk_cfg` is clamped to 4..256. `flush_way` is always the highest enabled way, and `flush_line_base` rises from 0 within that way.
- R5: No new chunk is issued while `irq_pending` is high or while either core is outside C4. Flushing resumes when the condition clears, and a fresh C4 entry reloads the budget.
- R6: When a chunk finishes the last line of a way, that way's `way_gate` bit sets and `ways_enabled` drops by one.
- R7: The active countdown reloads from `resid_reload` while `pkg_idle` is high and counts down while it is low. Once it reaches zero while active, shrinking is blocked and expansion is requested.
- R8: Any of these re-enables all ways and drops the remaining budget: frequency above threshold, countdown expiry, or a core changing into C1, C2 or C3 (codes 1 to 3).
- R9: A `deep_exit` pulse sets `ways_enabled` to max(2, current) and ungates those ways. It then holds `vclr_req` until `vclr_done` is seen.
- R10: `deep_ready` is high exactly while `ways_enabled` is zero, and all ways are then gated.
- R11: Way, base and count stay stable while `flush_req` waits for `flush_done`. Expansion or wake-up requests that arrive meanwhile take effect after the chunk completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_cur | input | 8 | Current frequency code |
| freq_thresh | input | 8 | Frequency limit for shrinking |
| core0_cst | input | 3 | Core 0 idle state, 0=C0 .. 4=C4 |
| core1_cst | input | 3 | Core 1 idle state, 0=C0 .. 4=C4 |
| pkg_idle | input | 1 | Whole package in C2..C4 |
| irq_pending | input | 1 | Interrupt waiting for service |
| deep_exit | input | 1 | Pulse: wake from deepest idle |
| resid_reload | input | 16 | Active-residency countdown reload value |
| frac_sel | input | 2 | Budget fraction per entry |
| chunk_cfg | input | 9 | Lines per chunk (clamped 4..256) |
| flush_req | output | 1 | Chunk flush request |
| flush_way | output | 3 | Way of the chunk |
| flush_line_base | output | 6 | First line of the chunk |
| flush_line_cnt | output | 9 | Lines in the chunk |
| flush_done | input | 1 | Flush engine completed chunk |
| way_gate | output | 8 | Per-way power-gate enable |
| vclr_req | output | 1 | Valid-bit clear request |
| vclr_done | input | 1 | Valid-bit clear completed |
| ways_enabled | output | 4 | Number of enabled ways |
| deep_ready | output | 1 | All ways gated |

## Verification
A corrupted line pointer or budget appears within one chunk as a wrong `flush_line_base` or `flush_line_cnt`, or as a way gated too early or too late. A stuck way counter shows at once as a `way_gate` population that does not match `ways_enabled`. Freeze and expansion errors appear a few cycles after the triggering input, as a chunk issued while blocked or as a way count that does not return to eight. Countdown errors appear only after the programmed number of active cycles, so the bench checks both just before and just after that point.

// File: rtl/resize_pkg.sv
package resize_pkg;
  typedef enum logic [2:0] {
    CS_C0 = 3'd0, CS_C1 = 3'd1, CS_C2 = 3'd2, CS_C3 = 3'd3, CS_C4 = 3'd4
  } cstate_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_CHUNK = 2'd1,
    SQ_VCLR  = 2'd2
  } seq_st_e;

  localparam int CHUNK_W   = 9;
  localparam int CHUNK_MIN = 4;
  localparam int CHUNK_MAX = 256;

  function automatic logic [CHUNK_W-1:0] clamp_chunk(input logic [CHUNK_W-1:0] v);
    if (int'(v) < CHUNK_MIN) return CHUNK_W'(CHUNK_MIN);
    if (int'(v) > CHUNK_MAX) return CHUNK_W'(CHUNK_MAX);
    return v;
  endfunction
endpackage

// File: rtl/resize_timer.sv
module resize_timer #(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pkg_idle,
  input  logic [TIMER_W-1:0] reload,
  output logic               expired
);
  logic [TIMER_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || pkg_idle)   count_q <= reload;
    else if (count_q != '0) count_q <= count_q - 1'b1;
  end

  assign expired = (count_q == '0) && !pkg_idle;

  // R7: the count never moves up unless it was reloaded by package idle
  assert_count_down_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(pkg_idle) && !pkg_idle |-> count_q <= $past(count_q));
endmodule

// File: rtl/resize_policy.sv
module resize_policy
  import resize_pkg::*;
#(
  parameter int FREQ_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FREQ_W-1:0] freq_cur,
  input  logic [FREQ_W-1:0] freq_thresh,
  input  logic [2:0]        core0_cst,
  input  logic [2:0]        core1_cst,
  input  logic              irq_pending,
  input  logic              expired,
  output logic              entry_evt,
  output logic              expand_evt,
  output logic              shrink_ok
);
  logic [2:0] prev0_q, prev1_q;
  logic both_c4, both_c4_prev, freq_low, freq_high;
  logic shallow0, shallow1;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev0_q <= CS_C0;
      prev1_q <= CS_C0;
    end else begin
      prev0_q <= core0_cst;
      prev1_q <= core1_cst;
    end
  end

  always_comb begin
    both_c4      = (core0_cst == CS_C4) && (core1_cst == CS_C4);
    both_c4_prev = (prev0_q == CS_C4) && (prev1_q == CS_C4);
    freq_low     = freq_cur < freq_thresh;
    freq_high    = freq_cur > freq_thresh;
    shallow0     = (core0_cst inside {CS_C1, CS_C2, CS_C3}) && (core0_cst != prev0_q);
    shallow1     = (core1_cst inside {CS_C1, CS_C2, CS_C3}) && (core1_cst != prev1_q);
    entry_evt    = both_c4 && !both_c4_prev && freq_low && !expired;
    expand_evt   = freq_high || expired || shallow0 || shallow1;
    shrink_ok    = both_c4 && !irq_pending && freq_low && !expired;
  end

  // R2: a qualifying entry needs a C4 transition seen against the registered history
  assert_entry_edge_R2: assert property (@(posedge clk) disable iff (rst)
    entry_evt |-> !((prev0_q == CS_C4) && (prev1_q == CS_C4)));
endmodule

// File: rtl/resize_flush_seq.sv
module resize_flush_seq
  import resize_pkg::*;
#(
  parameter int NUM_WAYS      = 8,
  parameter int LINES_PER_WAY = 64
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                entry_evt,
  input  logic                                expand_evt,
  input  logic                                dx_evt,
  input  logic                                shrink_ok,
  input  logic [1:0]                          frac_sel,
  input  logic [CHUNK_W-1:0]                  chunk_cfg,
  input  logic                                flush_done,
  input  logic                                vclr_done,
  output logic                                flush_req,
  output logic [$clog2(NUM_WAYS)-1:0]         flush_way,
  output logic [$clog2(LINES_PER_WAY)-1:0]    flush_line_base,
  output logic [CHUNK_W-1:0]                  flush_line_cnt,
  output logic [NUM_WAYS-1:0]                 way_gate,
  output logic                                vclr_req,
  output logic [$clog2(NUM_WAYS+1)-1:0]       ways_en,
  output logic                                deep_ready
);
  localparam int WAY_W  = $clog2(NUM_WAYS);
  localparam int LINE_W = $clog2(LINES_PER_WAY);
  localparam int CNT_W  = $clog2(NUM_WAYS+1);
  localparam int PTR_W  = $clog2(LINES_PER_WAY+1);
  localparam int TOTAL  = NUM_WAYS * LINES_PER_WAY;
  localparam int BUD_W  = $clog2(TOTAL+1);
  localparam int MIN_WAKE = (NUM_WAYS < 2) ? NUM_WAYS : 2;

  seq_st_e          st_q, st_n;
  logic [CNT_W-1:0] ways_n;
  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic [BUD_W-1:0] bud_q, bud_n;
  logic             pend_ent_q, pend_exp_q, pend_dx_q;
  logic             pend_ent_n, pend_exp_n, pend_dx_n;
  logic             req_n, vclr_n;
  logic [WAY_W-1:0] way_n;
  logic [LINE_W-1:0] base_n;
  logic [CHUNK_W-1:0] cnt_n;
  logic             take_ent, take_exp, take_dx;
  logic             gate_set, ungate;
  logic [WAY_W-1:0] gate_idx;
  logic [CNT_W-1:0] ungate_to;
  logic [BUD_W-1:0] frac_lines;
  logic [CHUNK_W-1:0] chunk_c;
  int unsigned      n_i, left_i;

  assign take_dx  = pend_dx_q  || dx_evt;
  assign take_exp = pend_exp_q || expand_evt;
  assign take_ent = pend_ent_q || entry_evt;
  assign chunk_c  = clamp_chunk(chunk_cfg);

  always_comb begin
    case (frac_sel)
      2'd0:    frac_lines = BUD_W'(TOTAL / 8);
      2'd1:    frac_lines = BUD_W'(TOTAL / 4);
      default: frac_lines = BUD_W'(TOTAL / 2);
    endcase
  end

  always_comb begin
    left_i = 32'(LINES_PER_WAY) - 32'(ptr_q);
    n_i    = 32'(chunk_c);
    if (left_i < n_i) n_i = left_i;
    if (32'(bud_q) < n_i) n_i = 32'(bud_q);
  end

  always_comb begin
    st_n       = st_q;
    ways_n     = ways_en;
    ptr_n      = ptr_q;
    bud_n      = bud_q;
    pend_ent_n = pend_ent_q || entry_evt;
    pend_exp_n = pend_exp_q || expand_evt;
    pend_dx_n  = pend_dx_q  || dx_evt;
    req_n      = flush_req;
    way_n      = flush_way;
    base_n     = flush_line_base;
    cnt_n      = flush_line_cnt;
    vclr_n     = vclr_req;
    gate_set   = 1'b0;
    gate_idx   = flush_way;
    ungate     = 1'b0;
    ungate_to  = ways_en;
    case (st_q)
      SQ_IDLE: begin
        pend_ent_n = 1'b0;
        pend_exp_n = 1'b0;
        pend_dx_n  = 1'b0;
        if (take_dx) begin
          ways_n    = (32'(ways_en) < MIN_WAKE) ? CNT_W'(MIN_WAKE) : ways_en;
          ptr_n     = '0;
          bud_n     = '0;
          ungate    = 1'b1;
          ungate_to = ways_n;
          vclr_n    = 1'b1;
          st_n      = SQ_VCLR;
        end else if (take_exp) begin
          ways_n    = CNT_W'(NUM_WAYS);
          ptr_n     = '0;
          bud_n     = '0;
          ungate    = 1'b1;
          ungate_to = CNT_W'(NUM_WAYS);
        end else if (take_ent) begin
          bud_n = frac_lines;
        end else if (bud_q != '0 && ways_en != '0 && shrink_ok) begin
          req_n  = 1'b1;
          way_n  = WAY_W'(ways_en - 1'b1);
          base_n = LINE_W'(ptr_q);
          cnt_n  = CHUNK_W'(n_i);
          st_n   = SQ_CHUNK;
        end
      end
      SQ_CHUNK: begin
        if (flush_done) begin
          req_n = 1'b0;
          bud_n = bud_q - BUD_W'(flush_line_cnt);
          if (32'(ptr_q) + 32'(flush_line_cnt) >= 32'(LINES_PER_WAY)) begin
            gate_set = 1'b1;
            gate_idx = flush_way;
            ways_n   = ways_en - 1'b1;
            ptr_n    = '0;
          end else begin
            ptr_n = ptr_q + PTR_W'(flush_line_cnt);
          end
          st_n = SQ_IDLE;
        end
      end
      SQ_VCLR: begin
        if (vclr_done) begin
          vclr_n = 1'b0;
          st_n   = SQ_IDLE;
        end
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q            <= SQ_IDLE;
      ways_en         <= CNT_W'(NUM_WAYS);
      ptr_q           <= '0;
      bud_q           <= '0;
      pend_ent_q      <= 1'b0;
      pend_exp_q      <= 1'b0;
      pend_dx_q       <= 1'b0;
      flush_req       <= 1'b0;
      flush_way       <= '0;
      flush_line_base <= '0;
      flush_line_cnt  <= '0;
      vclr_req        <= 1'b0;
      deep_ready      <= 1'b0;
    end else begin
      st_q            <= st_n;
      ways_en         <= ways_n;
      ptr_q           <= ptr_n;
      bud_q           <= bud_n;
      pend_ent_q      <= pend_ent_n;
      pend_exp_q      <= pend_exp_n;
      pend_dx_q       <= pend_dx_n;
      flush_req       <= req_n;
      flush_way       <= way_n;
      flush_line_base <= base_n;
      flush_line_cnt  <= cnt_n;
      vclr_req        <= vclr_n;
      deep_ready      <= (ways_n == '0);
    end
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_gate
    always_ff @(posedge clk) begin
      if (rst)                                        way_gate[w] <= 1'b0;
      else if (gate_set && gate_idx == WAY_W'(w))     way_gate[w] <= 1'b1;
      else if (ungate && w < int'(ungate_to))         way_gate[w] <= 1'b0;
    end
  end

  // R6: gated ways and enabled count always account for every way
  assert_gate_count_R6: assert property (@(posedge clk) disable iff (rst)
    ($countones(way_gate) + int'(ways_en)) == NUM_WAYS);

  // R11: chunk fields are frozen while the flush engine has not answered
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    flush_req && !flush_done |=> flush_req && $stable(flush_way)
      && $stable(flush_line_base) && $stable(flush_line_cnt));

  // R4: a chunk stays inside its way and targets the top enabled way
  assert_chunk_bounds_R4: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> (flush_line_cnt != '0) && (int'(flush_line_cnt) <= CHUNK_MAX)
      && (int'(flush_line_base) + int'(flush_line_cnt) <= LINES_PER_WAY)
      && (int'(flush_way) + 1 == int'(ways_en)));

  // R5: a new chunk is only launched when shrinking was permitted
  assert_no_freeze_issue_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(flush_req) |-> $past(shrink_ok));

  // R10: the ready flag implies every way is power-gated
  assert_deep_ready_R10: assert property (@(posedge clk) disable iff (rst)
    deep_ready |-> (&way_gate) && (ways_en == '0));

  // R9: valid clearing only happens with the wake-up minimum enabled
  assert_vclr_min_R9: assert property (@(posedge clk) disable iff (rst)
    vclr_req |-> int'(ways_en) >= MIN_WAKE);
endmodule

// File: rtl/cache_resize_ctrl.sv
module cache_resize_ctrl #(
  parameter int NUM_WAYS      = 8,
  parameter int LINES_PER_WAY = 64,
  parameter int FREQ_W        = 8,
  parameter int TIMER_W       = 16
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [FREQ_W-1:0]                  freq_cur,
  input  logic [FREQ_W-1:0]                  freq_thresh,
  input  logic [2:0]                         core0_cst,
  input  logic [2:0]                         core1_cst,
  input  logic                               pkg_idle,
  input  logic                               irq_pending,
  input  logic                               deep_exit,
  input  logic [TIMER_W-1:0]                 resid_reload,
  input  logic [1:0]                         frac_sel,
  input  logic [8:0]                         chunk_cfg,
  output logic                               flush_req,
  output logic [$clog2(NUM_WAYS)-1:0]        flush_way,
  output logic [$clog2(LINES_PER_WAY)-1:0]   flush_line_base,
  output logic [8:0]                         flush_line_cnt,
  input  logic                               flush_done,
  output logic [NUM_WAYS-1:0]                way_gate,
  output logic                               vclr_req,
  input  logic                               vclr_done,
  output logic [$clog2(NUM_WAYS+1)-1:0]      ways_enabled,
  output logic                               deep_ready
);
  logic expired, entry_evt, expand_evt, shrink_ok;

  resize_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .pkg_idle (pkg_idle),
    .reload   (resid_reload),
    .expired  (expired)
  );

  resize_policy #(.FREQ_W(FREQ_W)) u_policy (
    .clk         (clk),
    .rst         (rst),
    .freq_cur    (freq_cur),
    .freq_thresh (freq_thresh),
    .core0_cst   (core0_cst),
    .core1_cst   (core1_cst),
    .irq_pending (irq_pending),
    .expired     (expired),
    .entry_evt   (entry_evt),
    .expand_evt  (expand_evt),
    .shrink_ok   (shrink_ok)
  );

  resize_flush_seq #(.NUM_WAYS(NUM_WAYS), .LINES_PER_WAY(LINES_PER_WAY)) u_seq (
    .clk             (clk),
    .rst             (rst),
    .entry_evt       (entry_evt),
    .expand_evt      (expand_evt),
    .dx_evt          (deep_exit),
    .shrink_ok       (shrink_ok),
    .frac_sel        (frac_sel),
    .chunk_cfg       (chunk_cfg),
    .flush_done      (flush_done),
    .vclr_done       (vclr_done),
    .flush_req       (flush_req),
    .flush_way       (flush_way),
    .flush_line_base (flush_line_base),
    .flush_line_cnt  (flush_line_cnt),
    .way_gate        (way_gate),
    .vclr_req        (vclr_req),
    .ways_en         (ways_enabled),
    .deep_ready      (deep_ready)
  );
endmodule

// File: tb/cache_resize_ctrl_tb_top.sv
`timescale 1ns/1ps
module cache_resize_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] freq_cur = 8'd10, freq_thresh = 8'd50;
  logic [2:0] core0_cst = 3'd0, core1_cst = 3'd0;
  logic       pkg_idle = 1'b0, irq_pending = 1'b0, deep_exit = 1'b0;
  logic [15:0] resid_reload = 16'd1000;
  logic [1:0] frac_sel = 2'd0;
  logic [8:0] chunk_cfg = 9'd16;
  logic       flush_req, flush_done = 1'b0;
  logic [2:0] flush_way;
  logic [5:0] flush_line_base;
  logic [8:0] flush_line_cnt;
  logic [7:0] way_gate;
  logic       vclr_req, vclr_done = 1'b0;
  logic [3:0] ways_enabled;
  logic       deep_ready;

  int n_chk = 0, n_fail = 0;
  bit ack_en = 1'b1;
  bit finished = 1'b0;
  int log_n = 0;
  int log_way [64];
  int log_base[64];
  int log_cnt [64];

  always #5 clk = ~clk;

  cache_resize_ctrl dut_i (
    .clk(clk), .rst(rst), .freq_cur(freq_cur), .freq_thresh(freq_thresh),
    .core0_cst(core0_cst), .core1_cst(core1_cst), .pkg_idle(pkg_idle),
    .irq_pending(irq_pending), .deep_exit(deep_exit), .resid_reload(resid_reload),
    .frac_sel(frac_sel), .chunk_cfg(chunk_cfg), .flush_req(flush_req),
    .flush_way(flush_way), .flush_line_base(flush_line_base),
    .flush_line_cnt(flush_line_cnt), .flush_done(flush_done), .way_gate(way_gate),
    .vclr_req(vclr_req), .vclr_done(vclr_done), .ways_enabled(ways_enabled),
    .deep_ready(deep_ready)
  );

  // flush engine model: acknowledges each request one cycle after it appears
  always @(negedge clk) begin
    if (ack_en && flush_req && !flush_done) begin
      if (log_n < 64) begin
        log_way[log_n]  = int'(flush_way);
        log_base[log_n] = int'(flush_line_base);
        log_cnt[log_n]  = int'(flush_line_cnt);
      end
      log_n = log_n + 1;
      flush_done <= 1'b1;
    end else begin
      flush_done <= 1'b0;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cores(input logic [2:0] a, input logic [2:0] b);
    core0_cst = a;
    core1_cst = b;
    pkg_idle  = (a >= 3'd2) && (b >= 3'd2);
  endtask

  task automatic reenter_c4();
    cores(3'd0, 3'd0);
    tick(1);
    log_n = 0;
    cores(3'd4, 3'd4);
  endtask

  task automatic t_reset();
    tick(3);
    rst = 1'b0;
    tick(1);
    chk("R1 ways", ways_enabled, 8);
    chk("R1 gates", way_gate, 0);
    chk("R1 flush_req", flush_req, 0);
    chk("R1 vclr_req", vclr_req, 0);
    chk("R1 deep_ready", deep_ready, 0);
  endtask

  task automatic t_basic();
    frac_sel = 2'd0; chunk_cfg = 9'd16;
    reenter_c4();
    tick(40);
    chk("R2 chunks issued", log_n, 4);
    chk("R4 top way", log_way[0], 7);
    chk("R4 last base", log_base[3], 48);
    chk("R4 chunk size", log_cnt[0], 16);
    chk("R6 ways after way done", ways_enabled, 7);
    chk("R6 gate of way 7", way_gate, 8'h80);
  endtask

  task automatic t_boundary();
    frac_sel = 2'd1; chunk_cfg = 9'd48;
    reenter_c4();
    tick(40);
    chk("R3 quarter budget chunks", log_n, 4);
    chk("R4 way-end trim", log_cnt[1], 16);
    chk("R4 base after trim", log_base[2], 0);
    chk("R4 next way", log_way[2], 5);
    chk("R3 ways after quarter", ways_enabled, 5);
    chk("R6 gates", way_gate, 8'hE0);
  endtask

  task automatic t_clamp();
    frac_sel = 2'd0; chunk_cfg = 9'd2;
    reenter_c4();
    tick(80);
    chk("R4 clamp to 4", log_cnt[0], 4);
    chk("R4 clamp chunk count", log_n, 16);
    chk("R4 ways", ways_enabled, 4);
    chunk_cfg = 9'd16;
  endtask

  task automatic t_freq_equal();
    freq_cur = 8'd50;
    reenter_c4();
    tick(20);
    chk("R2 equal freq no flush", log_n, 0);
    chk("R8 equal freq no expand", ways_enabled, 4);
    freq_cur = 8'd10;
    tick(10);
    chk("R2 no late start", log_n, 0);
  endtask

  task automatic t_irq_freeze();
    irq_pending = 1'b1;
    reenter_c4();
    tick(20);
    chk("R5 irq blocks chunks", log_n, 0);
    chk("R5 irq keeps ways", ways_enabled, 4);
    irq_pending = 1'b0;
    tick(30);
    chk("R5 resumes after irq", log_n, 4);
    chk("R5 ways after resume", ways_enabled, 3);
  endtask

  task automatic t_core_wake();
    ack_en = 1'b0;
    reenter_c4();
    tick(5);
    chk("R5 chunk outstanding", flush_req, 1);
    cores(3'd4, 3'd0);
    ack_en = 1'b1;
    tick(20);
    chk("R5 only one chunk while core active", log_n, 1);
    chk("R5 way not gated yet", ways_enabled, 3);
    cores(3'd4, 3'd4);
    tick(30);
    chk("R5 fresh entry resumes", log_n, 5);
    chk("R5 continues at base", log_base[1], 16);
    chk("R5 next way after finish", log_way[4], 1);
    chk("R5 ways", ways_enabled, 2);
  endtask

  task automatic t_shallow_expand();
    cores(3'd4, 3'd2);
    tick(3);
    chk("R8 shallow idle expands", ways_enabled, 8);
    chk("R8 gates cleared", way_gate, 0);
  endtask

  task automatic t_freq_expand();
    reenter_c4();
    tick(30);
    chk("R8 shrink before rise", ways_enabled, 7);
    freq_cur = 8'd60;
    tick(3);
    chk("R8 freq above expands", ways_enabled, 8);
    freq_cur = 8'd10;
  endtask

  task automatic t_residency();
    resid_reload = 16'd20;
    reenter_c4();
    tick(30);
    chk("R7 shrink with timer", ways_enabled, 7);
    cores(3'd0, 3'd0);
    tick(12);
    chk("R7 not expired early", ways_enabled, 7);
    tick(15);
    chk("R7 expiry expands", ways_enabled, 8);
    log_n = 0;
    core0_cst = 3'd4; core1_cst = 3'd4; pkg_idle = 1'b0;
    tick(20);
    chk("R7 expired blocks shrink", log_n, 0);
    resid_reload = 16'd1000;
    pkg_idle = 1'b1;
    tick(2);
  endtask

  task automatic t_deep();
    frac_sel = 2'd2; chunk_cfg = 9'd256;
    reenter_c4();
    tick(30);
    chk("R3 half budget", ways_enabled, 4);
    reenter_c4();
    tick(30);
    chk("R10 zero ways", ways_enabled, 0);
    chk("R10 deep ready", deep_ready, 1);
    chk("R10 all gated", way_gate, 8'hFF);
    cores(3'd0, 3'd0);
    deep_exit = 1'b1;
    tick(1);
    deep_exit = 1'b0;
    tick(1);
    chk("R9 wake two ways", ways_enabled, 2);
    chk("R9 gates", way_gate, 8'hFC);
    chk("R10 ready drops", deep_ready, 0);
    tick(5);
    chk("R9 clear held", vclr_req, 1);
    vclr_done = 1'b1;
    tick(1);
    vclr_done = 1'b0;
    tick(1);
    chk("R9 clear released", vclr_req, 0);
  endtask

  task automatic t_deep_keep();
    frac_sel = 2'd0; chunk_cfg = 9'd16;
    cores(3'd1, 3'd0);
    tick(3);
    chk("R8 C1 expands", ways_enabled, 8);
    reenter_c4();
    tick(30);
    deep_exit = 1'b1;
    tick(1);
    deep_exit = 1'b0;
    tick(1);
    chk("R9 wake keeps larger count", ways_enabled, 7);
    chk("R9 clear asked", vclr_req, 1);
    vclr_done = 1'b1;
    tick(1);
    vclr_done = 1'b0;
    tick(2);
  endtask

  task automatic t_deferred();
    ack_en = 1'b0;
    reenter_c4();
    tick(5);
    freq_cur = 8'd60;
    tick(5);
    chk("R11 request held", flush_req, 1);
    chk("R11 way held", flush_way, 6);
    chk("R11 expansion deferred", ways_enabled, 7);
    ack_en = 1'b1;
    tick(5);
    chk("R11 expansion after done", ways_enabled, 8);
    chk("R11 request dropped", flush_req, 0);
    freq_cur = 8'd10;
  endtask

  initial begin
    t_reset();
    t_basic();
    t_boundary();
    t_clamp();
    t_freq_equal();
    t_irq_freeze();
    t_core_wake();
    t_shallow_expand();
    t_freq_expand();
    t_residency();
    t_deep();
    t_deep_keep();
    t_deferred();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule